// File: doc/BRIEF.md
# EPROM Byte Programming Sequencer

This block drives the pins of a byte-wide UV-erasable EPROM to write one byte and then read it back to confirm it. The host places an address and a data byte on the request inputs and pulses `start`. The sequencer then works through the whole cycle without further help from the host. It raises the core supply first and the programming voltage second. It puts the address and data on the buses and waits out the setup time. It then holds the combined chip-enable/program line low for one program pulse. After the data hold time it releases the data bus and reads the cell back through output-enable. At the end it removes the two supplies in reverse order.

Each read-back is compared with the requested byte. A parameter allows a bounded number of extra program pulses when the read-back does not match. If the byte still does not match once those pulses are used up, the block reports a failure and keeps both the requested byte and the byte it read. All delays are set in nanoseconds and turned into clock cycles from a clock-frequency parameter, rounding up. The host sees a simple start/busy/done handshake with a pass or fail result.

Top module: `eprom_prog_seq`

## Requirements
- R1: After reset, and whenever idle, both supply enables are low, `ep_ce_n` and `ep_oe_n` are high, `ep_dq_oe` is low, `busy`, `done`, `pass` and `fail` are low.
- R2: `vpp_en` rises only while `vcc_en` has already been high for at least 1 µs and `ep_ce_n` is high.
- R3: `vcc_en` never falls while `vpp_en` is high, or in the same cycle that `vpp_en` falls.
- R4: When `ep_ce_n` falls, three conditions have held for at least 1 µs: the data bus has been driven with a stable value, `vpp_en` has been high, and `ep_oe_n` has been high.
- R5: Each program pulse (`ep_ce_n` low) lasts at least 45 µs and at most 105 µs.
- R6: After `ep_ce_n` rises, the data bus stays driven with the same byte for at least 1 µs. `ep_addr` does not change for the whole time `busy` is high.
- R7: `ep_dq_oe` and a low `ep_oe_n` never occur in the same cycle. `ep_dq_oe` is already low in the cycle before `ep_oe_n` falls. `ep_dq_oe` rises again only after `ep_oe_n` has been high for at least 60 ns.
- R8: The read-back byte is sampled only after `ep_oe_n` has been low for at least 100 ns. A byte that matches on the first read-back ends with `pass` high, after exactly one program pulse.
- R9: If the read-back still mismatches when no retries remain, the operation ends with `fail` high, `fail_exp` holding the requested byte and `fail_read` holding the byte read.
- R10: After a mismatch, the sequencer applies another setup and program pulse, up to MAX_RETRY extra pulses. A byte that verifies on pulse n (n ≤ 1+MAX_RETRY) passes with exactly n pulses. A byte that never verifies gets exactly 1+MAX_RETRY pulses.
- R11: `start` is taken only when idle, and `busy` is high from the cycle after it. While `busy` is high, `start` and the request inputs are ignored. `done` is a single-cycle pulse in the cycle `busy` falls, and `pass`/`fail` hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to program one byte |
| prog_addr | input | ADDR_W | Byte address for the request |
| prog_data | input | 8 | Byte value to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| pass | output | 1 | Last operation verified |
| fail | output | 1 | Last operation failed verify |
| fail_exp | output | 8 | Requested byte of the last mismatch |
| fail_read | output | 8 | Read-back byte of the last mismatch |
| vcc_en | output | 1 | Enable for the raised core supply |
| vpp_en | output | 1 | Enable for the programming voltage |
| ep_addr | output | ADDR_W | EPROM address bus |
| ep_dq_out | output | 8 | Data to drive onto the EPROM data bus |
| ep_dq_oe | output | 1 | Drive enable for the data bus (1 = drive) |
| ep_dq_in | input | 8 | Data bus value read from the EPROM |
| ep_ce_n | output | 1 | Active-low chip-enable/program |
| ep_oe_n | output | 1 | Active-low output-enable |

## Verification
The bench attaches a behavioural EPROM in which programming can only clear bits. In that model each cell can be set to need several pulses before it takes its value. The model returns a garbage byte until output-enable has been low for the access time, so any read-back sampled too early will show up. The main function is tried with several patterns. A cell that programs on the first pulse checks the basic pass path and the pulse count of one. An all-zero byte checks a different data value on the same path. A weak cell that needs three pulses separates the retry path from the single-pulse path. A cell that needs one pulse more than allowed separates the bounded retry from an endless loop. A cell that already holds cleared bits that the new byte needs set gives a failure whose read byte differs from the erased value. A second start during a busy operation, carrying a different address, shows whether requests are ignored while busy.

// File: rtl/eprom_prog_pkg.sv
package eprom_prog_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_VCC_UP,
    ST_VPP_UP,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_VERIFY,
    ST_COMPARE,
    ST_DONE,
    ST_FAIL
  } seq_state_t;

  // Converts a delay in ns to clock cycles, rounding up.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/prog_timer.sv
module prog_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

  // R5
  timer_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q == '0) |=> (cnt_q == '0));

  // R5
  timer_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/prog_verify.sv
module prog_verify #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          capture,
  input  logic [DW-1:0] expected,
  input  logic [DW-1:0] rd_in,
  output logic          match,
  output logic [DW-1:0] exp_o,
  output logic [DW-1:0] rd_o
);

  logic          match_q;
  logic [DW-1:0] exp_q;
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      match_q <= 1'b0;
      exp_q   <= '0;
      rd_q    <= '0;
    end else if (capture) begin
      match_q <= (rd_in == expected);
      if (rd_in != expected) begin
        exp_q <= expected;
        rd_q  <= rd_in;
      end
    end
  end

  assign match = match_q;
  assign exp_o = exp_q;
  assign rd_o  = rd_q;

  // R9
  mism_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!capture && !clr) |=> ($stable(exp_q) && $stable(rd_q)));

endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
  import eprom_prog_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int CLK_MHZ     = 125,
  parameter int T_SETUP_NS  = 1000,
  parameter int T_PULSE_NS  = 50000,
  parameter int T_DHOLD_NS  = 1000,
  parameter int T_OEV_NS    = 100,
  parameter int T_FLOAT_NS  = 60,
  parameter int MAX_RETRY   = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [7:0]        prog_data,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [7:0]        fail_exp,
  output logic [7:0]        fail_read,
  output logic              vcc_en,
  output logic              vpp_en,
  output logic [ADDR_W-1:0] ep_addr,
  output logic [7:0]        ep_dq_out,
  output logic              ep_dq_oe,
  input  logic [7:0]        ep_dq_in,
  output logic              ep_ce_n,
  output logic              ep_oe_n
);

  localparam int unsigned SETUP_CYC = ns_to_cyc(T_SETUP_NS, CLK_MHZ);
  localparam int unsigned PULSE_CYC = ns_to_cyc(T_PULSE_NS, CLK_MHZ);
  localparam int unsigned DHOLD_CYC = ns_to_cyc(T_DHOLD_NS, CLK_MHZ);
  localparam int unsigned OEV_CYC   = ns_to_cyc(T_OEV_NS, CLK_MHZ) + 1;
  localparam int unsigned FLOAT_CYC = ns_to_cyc(T_FLOAT_NS, CLK_MHZ);
  localparam int unsigned MAX_CYC   = max2(max2(SETUP_CYC, PULSE_CYC),
                                           max2(max2(DHOLD_CYC, OEV_CYC), FLOAT_CYC));
  localparam int TMR_W = $clog2(MAX_CYC + 1) + 1;
  localparam int RTY_W = $clog2(MAX_RETRY + 2);

  localparam logic [TMR_W-1:0] LD_SETUP = TMR_W'(SETUP_CYC);
  localparam logic [TMR_W-1:0] LD_PULSE = TMR_W'(PULSE_CYC);
  localparam logic [TMR_W-1:0] LD_DHOLD = TMR_W'(DHOLD_CYC);
  localparam logic [TMR_W-1:0] LD_OEV   = TMR_W'(OEV_CYC);
  localparam logic [TMR_W-1:0] LD_FLOAT = TMR_W'(FLOAT_CYC);
  localparam logic [RTY_W-1:0] RTY_INIT = RTY_W'(MAX_RETRY);

  seq_state_t        state_q, state_d;
  logic              tmr_ld;
  logic [TMR_W-1:0]  tmr_val;
  logic              tmr_zero;
  logic [RTY_W-1:0]  rty_left_q;
  logic              accept;
  logic              capture;
  logic              vfy_match;

  logic              busy_q, done_q, pass_q, fail_q;
  logic              vcc_q, vpp_q, ce_n_q, oe_n_q, dq_oe_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;

  assign accept  = (state_q == ST_IDLE) && start;
  assign capture = (state_q == ST_VERIFY) && tmr_zero;

  prog_timer #(.W(TMR_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_ld),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  prog_verify #(.DW(8)) u_verify (
    .clk      (clk),
    .rst      (rst),
    .clr      (accept),
    .capture  (capture),
    .expected (data_q),
    .rd_in    (ep_dq_in),
    .match    (vfy_match),
    .exp_o    (fail_exp),
    .rd_o     (fail_read)
  );

  always_comb begin
    state_d = state_q;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_VCC_UP;
          tmr_ld  = 1'b1;
          tmr_val = LD_SETUP;
        end
      end
      ST_VCC_UP: begin
        if (tmr_zero) begin
          state_d = ST_VPP_UP;
          tmr_ld  = 1'b1;
          tmr_val = LD_SETUP;
        end
      end
      ST_VPP_UP: begin
        if (tmr_zero) begin
          state_d = ST_SETUP;
          tmr_ld  = 1'b1;
          tmr_val = LD_SETUP;
        end
      end
      ST_SETUP: begin
        if (tmr_zero) begin
          state_d = ST_PULSE;
          tmr_ld  = 1'b1;
          tmr_val = LD_PULSE;
        end
      end
      ST_PULSE: begin
        if (tmr_zero) begin
          state_d = ST_HOLD;
          tmr_ld  = 1'b1;
          tmr_val = LD_DHOLD;
        end
      end
      ST_HOLD: begin
        if (tmr_zero) begin
          state_d = ST_VERIFY;
          tmr_ld  = 1'b1;
          tmr_val = LD_OEV;
        end
      end
      ST_VERIFY: begin
        if (tmr_zero) begin
          state_d = ST_COMPARE;
          tmr_ld  = 1'b1;
          tmr_val = LD_FLOAT;
        end
      end
      ST_COMPARE: begin
        if (tmr_zero) begin
          tmr_ld  = 1'b1;
          tmr_val = LD_SETUP;
          if (vfy_match)              state_d = ST_DONE;
          else if (rty_left_q != '0)  state_d = ST_SETUP;
          else                        state_d = ST_FAIL;
        end
      end
      ST_DONE, ST_FAIL: begin
        if (tmr_zero) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      rty_left_q <= '0;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      pass_q     <= 1'b0;
      fail_q     <= 1'b0;
      vcc_q      <= 1'b0;
      vpp_q      <= 1'b0;
      ce_n_q     <= 1'b1;
      oe_n_q     <= 1'b1;
      dq_oe_q    <= 1'b0;
      addr_q     <= '0;
      data_q     <= '0;
    end else begin
      state_q <= state_d;
      busy_q  <= (state_d != ST_IDLE);
      vcc_q   <= (state_d != ST_IDLE);
      vpp_q   <= (state_d inside {ST_VPP_UP, ST_SETUP, ST_PULSE, ST_HOLD,
                                  ST_VERIFY, ST_COMPARE});
      ce_n_q  <= (state_d != ST_PULSE);
      oe_n_q  <= !((state_d == ST_VERIFY) && (state_q == ST_VERIFY));
      dq_oe_q <= (state_d inside {ST_SETUP, ST_PULSE, ST_HOLD});
      done_q  <= (state_q inside {ST_DONE, ST_FAIL}) && (state_d == ST_IDLE);
      if (accept) begin
        addr_q     <= prog_addr;
        data_q     <= prog_data;
        rty_left_q <= RTY_INIT;
        pass_q     <= 1'b0;
        fail_q     <= 1'b0;
      end else if ((state_q == ST_COMPARE) && (state_d == ST_SETUP)) begin
        rty_left_q <= rty_left_q - 1'b1;
      end
      if ((state_q == ST_DONE) && (state_d == ST_IDLE)) pass_q <= 1'b1;
      if ((state_q == ST_FAIL) && (state_d == ST_IDLE)) fail_q <= 1'b1;
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign pass      = pass_q;
  assign fail      = fail_q;
  assign vcc_en    = vcc_q;
  assign vpp_en    = vpp_q;
  assign ep_addr   = addr_q;
  assign ep_dq_out = data_q;
  assign ep_dq_oe  = dq_oe_q;
  assign ep_ce_n   = ce_n_q;
  assign ep_oe_n   = oe_n_q;

  // R2
  vpp_order_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(vpp_q) |-> (vcc_q && $past(vcc_q) && ce_n_q));

  // R3
  vcc_order_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(vcc_q) |-> (!vpp_q && !$past(vpp_q)));

  // R4
  pulse_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ce_n_q) |-> (dq_oe_q && $past(dq_oe_q) && vpp_q && oe_n_q));

  // R7
  bus_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(dq_oe_q && !oe_n_q));

  // R7
  oe_turn_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(oe_n_q) |-> !$past(dq_oe_q));

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> $stable(addr_q));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (!busy_q && (pass_q != fail_q)));

endmodule

// File: tb/tb_eprom_prog_seq.sv
module tb_eprom_prog_seq;

  localparam int AW     = 19;
  localparam int NRETRY = 2;
  // 8 ns clock: minimum times in cycles, rounded up
  localparam int SETUP_MIN = 125;    // 1 us
  localparam int PULSE_MIN = 5625;   // 45 us
  localparam int PULSE_MAX = 13125;  // 105 us
  localparam int DHOLD_MIN = 125;    // 1 us
  localparam int OEV_MIN   = 13;     // 100 ns
  localparam int FLOAT_MIN = 8;      // 60 ns

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] prog_addr = '0;
  logic [7:0]    prog_data = '0;
  logic          busy, done, pass, fail;
  logic [7:0]    fail_exp, fail_read;
  logic          vcc_en, vpp_en;
  logic [AW-1:0] ep_addr;
  logic [7:0]    ep_dq_out;
  logic          ep_dq_oe;
  logic [7:0]    ep_dq_in;
  logic          ep_ce_n, ep_oe_n;

  always #4 clk = ~clk;

  eprom_prog_seq #(.ADDR_W(AW), .CLK_MHZ(125), .MAX_RETRY(NRETRY)) dut (
    .clk(clk), .rst(rst), .start(start), .prog_addr(prog_addr), .prog_data(prog_data),
    .busy(busy), .done(done), .pass(pass), .fail(fail),
    .fail_exp(fail_exp), .fail_read(fail_read),
    .vcc_en(vcc_en), .vpp_en(vpp_en), .ep_addr(ep_addr),
    .ep_dq_out(ep_dq_out), .ep_dq_oe(ep_dq_oe), .ep_dq_in(ep_dq_in),
    .ep_ce_n(ep_ce_n), .ep_oe_n(ep_oe_n)
  );

  int errors = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- EPROM model: programming only clears bits ----------------
  logic [7:0] mem   [256];
  int         need  [256];
  int         pcnt  [256];
  int         oe_lo_run = 0;
  logic [7:0] pdata;
  logic [7:0] paddr;

  assign ep_dq_in = (!ep_oe_n && oe_lo_run >= OEV_MIN) ? mem[ep_addr[7:0]] : 8'hEE;

  // ---------------- pin monitor ----------------
  int r2_bad = 0, r3_bad = 0, r4_bad = 0, r5_bad = 0, r6_bad = 0, r7_bad = 0;
  int op_pulses = 0;
  int vcc_run = 0, vpp_run = 0, drv_run = 0, lo_run = 0, since_rise = 1000, oe_hi_run = 1000;
  logic vcc_p = 0, vpp_p = 0, ce_p = 1, oe_p = 1, drv_p = 0, busy_p = 0;
  logic [7:0]    dout_p = '0;
  logic [AW-1:0] addr_p = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (vpp_en && !vpp_p && (vcc_run < SETUP_MIN || !ep_ce_n)) r2_bad++;
      if (!vcc_en && vcc_p && (vpp_en || vpp_p)) r3_bad++;
      if (!ep_ce_n && ce_p) begin
        if (drv_run < SETUP_MIN || vpp_run < SETUP_MIN || !ep_oe_n || !oe_p) r4_bad++;
        pdata = ep_dq_out;
        paddr = ep_addr[7:0];
      end
      if (ep_ce_n && !ce_p) begin
        if (lo_run < PULSE_MIN || lo_run > PULSE_MAX) r5_bad++;
        op_pulses++;
        if (vpp_en && vcc_en) begin
          pcnt[paddr]++;
          if (pcnt[paddr] >= need[paddr]) mem[paddr] = mem[paddr] & pdata;
        end
      end
      if (!ep_dq_oe && drv_p && since_rise < DHOLD_MIN) r6_bad++;
      if (ep_dq_oe && drv_p && ep_dq_out != dout_p) r6_bad++;
      if (busy && busy_p && ep_addr != addr_p) r6_bad++;
      if (ep_dq_oe && !ep_oe_n) r7_bad++;
      if (!ep_oe_n && oe_p && drv_p) r7_bad++;
      if (ep_dq_oe && !drv_p && oe_hi_run < FLOAT_MIN) r7_bad++;
    end
    vcc_run    = vcc_en ? vcc_run + 1 : 0;
    vpp_run    = vpp_en ? vpp_run + 1 : 0;
    drv_run    = (ep_dq_oe && drv_p && ep_dq_out == dout_p) ? drv_run + 1 : (ep_dq_oe ? 1 : 0);
    lo_run     = !ep_ce_n ? lo_run + 1 : 0;
    since_rise = (ep_ce_n && !ce_p) ? 0 : since_rise + 1;
    oe_hi_run  = ep_oe_n ? oe_hi_run + 1 : 0;
    oe_lo_run  = !ep_oe_n ? oe_lo_run + 1 : 0;
    vcc_p = vcc_en; vpp_p = vpp_en; ce_p = ep_ce_n; oe_p = ep_oe_n;
    drv_p = ep_dq_oe; dout_p = ep_dq_out; addr_p = ep_addr; busy_p = busy;
  end

  // ---------------- host operation ----------------
  logic       res_pass, res_fail;
  logic [7:0] res_exp, res_read;

  task automatic run_byte(input logic [AW-1:0] a, input logic [7:0] d, input bit poke_busy);
    int guard;
    @(negedge clk);
    prog_addr = a;
    prog_data = d;
    start     = 1'b1;
    op_pulses = 0;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R11 busy after start", busy, 1);
    if (poke_busy) begin
      repeat (200) @(negedge clk);
      prog_addr = a + 1;
      prog_data = 8'h00;
      start     = 1'b1;
      @(negedge clk);
      start     = 1'b0;
    end
    guard = 0;
    while (!done && guard < 60000) begin
      @(negedge clk);
      guard++;
    end
    chk(guard < 60000, "R11 watchdog on done", guard, 0);
    chk(busy == 1'b0, "R11 busy low with done", busy, 0);
    res_pass = pass; res_fail = fail; res_exp = fail_exp; res_read = fail_read;
    @(negedge clk);
    chk(done == 1'b0, "R11 done single cycle", done, 0);
    chk(pass == res_pass && fail == res_fail, "R11 result held", {pass, fail}, {res_pass, res_fail});
  endtask

  task automatic t_reset;
    chk(!vcc_en && !vpp_en, "R1 supplies off", {vcc_en, vpp_en}, 0);
    chk(ep_ce_n && ep_oe_n, "R1 controls high", {ep_ce_n, ep_oe_n}, 3);
    chk(!ep_dq_oe, "R1 bus released", ep_dq_oe, 0);
    chk(!busy && !done && !pass && !fail, "R1 host idle", {busy, done, pass, fail}, 0);
  endtask

  task automatic t_basic;
    run_byte(19'h00003, 8'hA5, 1'b0);
    chk(res_pass && !res_fail, "R8 pass on first pulse", {res_pass, res_fail}, 2);
    chk(op_pulses == 1, "R8 one pulse", op_pulses, 1);
    chk(mem[3] == 8'hA5, "R8 cell content", mem[3], 8'hA5);
    chk(!vcc_en && !vpp_en && !ep_dq_oe, "R1 idle after op", {vcc_en, vpp_en, ep_dq_oe}, 0);
  endtask

  task automatic t_zero;
    run_byte(19'h40007, 8'h00, 1'b0);
    chk(res_pass, "R8 zero byte passes", res_pass, 1);
    chk(mem[7] == 8'h00, "R8 zero cell", mem[7], 0);
  endtask

  task automatic t_retry;
    need[9] = 3;
    run_byte(19'h00009, 8'h3C, 1'b0);
    chk(res_pass && !res_fail, "R10 pass after retries", {res_pass, res_fail}, 2);
    chk(op_pulses == 3, "R10 pulse count weak cell", op_pulses, 3);
  endtask

  task automatic t_fail_weak;
    need[10] = NRETRY + 2;
    run_byte(19'h0000A, 8'h5A, 1'b0);
    chk(res_fail && !res_pass, "R9 fail flagged", {res_pass, res_fail}, 1);
    chk(op_pulses == NRETRY + 1, "R10 bounded pulses", op_pulses, NRETRY + 1);
    chk(res_exp == 8'h5A, "R9 expected byte", res_exp, 8'h5A);
    chk(res_read == 8'hFF, "R9 read byte", res_read, 8'hFF);
  endtask

  task automatic t_conflict;
    mem[11] = 8'h0F;
    run_byte(19'h0000B, 8'hF0, 1'b0);
    chk(res_fail, "R9 conflict fails", res_fail, 1);
    chk(res_exp == 8'hF0, "R9 conflict expected", res_exp, 8'hF0);
    chk(res_read == 8'h00, "R9 conflict read", res_read, 8'h00);
  endtask

  task automatic t_busy_start;
    run_byte(19'h00020, 8'h81, 1'b1);
    chk(res_pass, "R11 op passes despite start", res_pass, 1);
    chk(op_pulses == 1, "R11 no extra pulses", op_pulses, 1);
    chk(mem[8'h21] == 8'hFF, "R11 ignored request untouched", mem[8'h21], 8'hFF);
    repeat (20) @(negedge clk);
    chk(!busy && !done, "R11 no second op", {busy, done}, 0);
  endtask

  task automatic t_pins;
    chk(r2_bad == 0, "R2 vpp order", r2_bad, 0);
    chk(r3_bad == 0, "R3 vcc order", r3_bad, 0);
    chk(r4_bad == 0, "R4 setup before pulse", r4_bad, 0);
    chk(r5_bad == 0, "R5 pulse width", r5_bad, 0);
    chk(r6_bad == 0, "R6 hold", r6_bad, 0);
    chk(r7_bad == 0, "R7 bus turnaround", r7_bad, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]  = 8'hFF;
      need[i] = 1;
      pcnt[i] = 0;
    end
    repeat (4) @(negedge clk);
    t_reset;
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset;
    t_basic;
    t_zero;
    t_retry;
    t_fail_weak;
    t_conflict;
    t_busy_start;
    t_pins;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R11 watchdog expired: actual=%0h expected=%0h", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule